// File: doc/BRIEF.md
# SPI Master Block Engine

This engine is a single-lane SPI master. One command word configures it: clock polarity and phase, which of four chip-select lines to use, the bit order, separate transmit and receive enables, and a block length between 1 and 32 bits. A write to the command word with the start bit set shifts exactly one block. At that start the engine takes one word from a show-ahead transmit FIFO. When the block ends it can hand the captured word to a receive FIFO.

Completion raises a sticky ready flag in a separate status word. Software clears the flag by writing a one to it. Chip select is normally asserted by hardware for the duration of a block. Software can instead take direct control of the selected line through a control bit and a value bit.

The serial clock runs at the system clock divided by 2×(DIV+1). The shift and capture edges follow the programmed clock mode.

Top module: `spi_blk_engine`

## Requirements
- R1: After reset the command readback, status readback and serial clock are 0 and every chip select is high. A command write (reg_sel=0) with bit 31 set while idle starts a block. Readback bit 31 reads 1 while the block runs and 0 after it ends. Bit 30 (master) and the other configuration fields read back as written.
- R2: Command bits 4:0 hold the block length minus one. A block produces exactly that value plus one capture edges on the serial clock.
- R3: Status bit 30 (ready) becomes 1 in the same cycle that command readback bit 31 returns to 0 at the end of a block.
- R4: A status write (reg_sel=1) with bit 30 set clears ready. A status write with bit 30 clear leaves ready unchanged.
- R5: Command bit 29 is the clock polarity, which is the idle level of the serial clock. Command bit 28 is the clock phase: 0 captures on the leading edge and shifts on the trailing edge, and 1 does the reverse.
- R6: Command bits 27:26 select one of the four chip-select outputs. When bit 21 is 0, the selected line is low only while a block runs, and all other lines stay high.
- R7: When command bit 21 is 1, the selected chip-select line equals command bit 20 at all times, with or without a running block. All other lines stay high.
- R8: When command bit 11 is 1, the start pops one transmit word and the engine shifts that word out. When bit 11 is 0, there is no pop and the data output is 0 for the whole block.
- R9: When command bit 12 is 1, the captured word is pushed once at block end, with all bits at or above the block length at 0. When bit 12 is 0, nothing is pushed.
- R10: When command bit 16 is 1, bit 0 of the block goes out first and the first captured bit lands in bit 0. When bit 16 is 0, bit (length−1) goes out first and the first captured bit lands in bit (length−1).
- R11: A command write while a block runs is ignored: the configuration readback and the running block are unchanged, and no second block starts.
- R12: Each half period of the serial clock lasts DIV+1 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command word, 1 selects the status word |
| reg_wdata | input | 32 | Register write data |
| cmd_rdata | output | 32 | Command readback; bit 31 shows that a block is running |
| sts_rdata | output | 32 | Status readback; bit 30 is ready |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_pop | output | 1 | Pops the transmit FIFO at a start that has transmit enabled |
| rx_data | output | 32 | Captured word for the receive FIFO |
| rx_push | output | 1 | Pushes rx_data, one pulse per block |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The properties assume the following about the environment:
- The transmit FIFO always has a word at its head when a start is written.
- miso is stable around every capture edge.
- The register port writes at most one word per cycle.

The stimulus meets these assumptions as follows:
- The bench holds tx_data constant for the whole of each block.
- A slave model in the bench changes miso only on the shift edge of the programmed mode, half a serial period before the engine captures it.
- The bench changes the clock mode only in a write without the start bit, then lets the idle level settle before it arms the slave model. A polarity change therefore never looks like a shift edge.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 5;
    localparam int CS_W   = 2;
    localparam int NCS    = 1 << CS_W;
    localparam int ECNT_W = LEN_W + 1;

    // Command word bit positions
    localparam int B_GO    = 31;
    localparam int B_MST   = 30;
    localparam int B_MODE  = 28;
    localparam int B_CSSEL = 26;
    localparam int B_CSSW  = 21;
    localparam int B_CSVAL = 20;
    localparam int B_LSB   = 16;
    localparam int B_RXEN  = 12;
    localparam int B_TXEN  = 11;
    // Status word bit position
    localparam int B_RDY   = 30;

    typedef struct packed {
        logic              master;
        logic [1:0]        mode;      // [1] polarity, [0] phase
        logic [CS_W-1:0]   cs_sel;
        logic              cs_sw;
        logic              cs_val;
        logic              lsb_first;
        logic              rx_en;
        logic              tx_en;
        logic [LEN_W-1:0]  len_m1;
    } cmd_t;

    typedef struct packed {
        logic              busy;
        cmd_t              cmd;
        logic              rdy;
        logic [ECNT_W-1:0] ecnt;
        logic [DATA_W-1:0] rxd;
        logic              rxp;
        logic [NCS-1:0]    csn;
    } eng_st_t;

    function automatic cmd_t cmd_unpack(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.master    = w[B_MST];
        c.mode      = w[B_MODE +: 2];
        c.cs_sel    = w[B_CSSEL +: CS_W];
        c.cs_sw     = w[B_CSSW];
        c.cs_val    = w[B_CSVAL];
        c.lsb_first = w[B_LSB];
        c.rx_en     = w[B_RXEN];
        c.tx_en     = w[B_TXEN];
        c.len_m1    = w[LEN_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cmd_pack(input cmd_t c, input logic busy);
        logic [DATA_W-1:0] w;
        w                 = '0;
        w[B_GO]           = busy;
        w[B_MST]          = c.master;
        w[B_MODE +: 2]    = c.mode;
        w[B_CSSEL +: CS_W] = c.cs_sel;
        w[B_CSSW]         = c.cs_sw;
        w[B_CSVAL]        = c.cs_val;
        w[B_LSB]          = c.lsb_first;
        w[B_RXEN]         = c.rx_en;
        w[B_TXEN]         = c.tx_en;
        w[LEN_W-1:0]      = c.len_m1;
        return w;
    endfunction
endpackage

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cpol,
    output logic sclk,
    output logic edge_stb
);
    localparam int CW = (DIV < 1) ? 1 : $clog2(DIV + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } cg_st_t;

    cg_st_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        edge_stb = run && (s_q.cnt == CW'(DIV));
        if (!run) begin
            s_d.cnt  = '0;
            s_d.sclk = cpol;
        end else if (edge_stb) begin
            s_d.cnt  = '0;
            s_d.sclk = ~s_q.sclk;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk = s_q.sclk;
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              lsb_first,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_fin
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } sh_st_t;

    sh_st_t s_q, s_d;
    logic [DATA_W-1:0] rx_nxt;

    always_comb begin
        s_d = s_q;
        if (sample_en)
            rx_nxt = lsb_first ? {miso, s_q.rx[DATA_W-1:1]} : {s_q.rx[DATA_W-2:0], miso};
        else
            rx_nxt = s_q.rx;
        // LSB-first words fill from the top; align them down to bit 0
        rx_fin = lsb_first ? (rx_nxt >> (LEN_W'(DATA_W - 1) - len_m1)) : rx_nxt;

        if (load) begin
            s_d.tx = load_val;
            s_d.rx = '0;
        end else begin
            s_d.rx = rx_nxt;
            if (shift_en)
                s_d.tx = lsb_first ? {1'b0, s_q.tx[DATA_W-1:1]} : {s_q.tx[DATA_W-2:0], 1'b0};
        end
        mosi = lsb_first ? s_q.tx[0] : s_q.tx[len_m1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/spi_blk_engine.sv
module spi_blk_engine
    import spi_eng_pkg::*;
#(
    parameter int DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic [DATA_W-1:0] sts_rdata,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_push,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_n
);
    eng_st_t s_q, s_d;

    logic              edge_stb;
    logic              start;
    logic              last_edge;
    logic              shift_en;
    logic              sample_en;
    logic              cs_active;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] rx_fin;
    cmd_t              new_cmd;

    spi_eng_clkgen #(.DIV(DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (s_q.busy),
        .cpol     (s_q.cmd.mode[1]),
        .sclk     (sclk),
        .edge_stb (edge_stb)
    );

    spi_eng_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_val  (load_val),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .lsb_first (s_q.cmd.lsb_first),
        .len_m1    (s_q.cmd.len_m1),
        .miso      (miso),
        .mosi      (mosi),
        .rx_fin    (rx_fin)
    );

    always_comb begin
        s_d       = s_q;
        new_cmd   = cmd_unpack(reg_wdata);
        start     = reg_we && !reg_sel && reg_wdata[B_GO] && !s_q.busy;
        tx_pop    = start && new_cmd.tx_en;
        load_val  = new_cmd.tx_en ? tx_data : '0;
        last_edge = s_q.busy && edge_stb && (s_q.ecnt == {s_q.cmd.len_m1, 1'b1});
        // Edge k: even = leading, odd = trailing
        sample_en = s_q.busy && edge_stb && (s_q.ecnt[0] == s_q.cmd.mode[0]);
        shift_en  = s_q.busy && edge_stb && (s_q.ecnt != '0) && (s_q.ecnt[0] != s_q.cmd.mode[0]);

        // Configuration is frozen while a block runs
        if (reg_we && !reg_sel && !s_q.busy)
            s_d.cmd = new_cmd;

        if (start) begin
            s_d.busy = 1'b1;
            s_d.ecnt = '0;
        end else if (s_q.busy && edge_stb) begin
            s_d.ecnt = s_q.ecnt + 1'b1;
            if (last_edge)
                s_d.busy = 1'b0;
        end

        if (reg_we && reg_sel && reg_wdata[B_RDY])
            s_d.rdy = 1'b0;
        if (last_edge)
            s_d.rdy = 1'b1;

        s_d.rxp = last_edge && s_q.cmd.rx_en;
        if (last_edge)
            s_d.rxd = rx_fin;

        cs_active = s_d.cmd.cs_sw ? !s_d.cmd.cs_val : s_d.busy;
        for (int i = 0; i < NCS; i++)
            s_d.csn[i] = !(cs_active && (s_d.cmd.cs_sel == CS_W'(i)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.csn <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_rdata = cmd_pack(s_q.cmd, s_q.busy);
    assign sts_rdata = {{(DATA_W-1-B_RDY){1'b0}}, s_q.rdy, {B_RDY{1'b0}}};
    assign rx_data   = s_q.rxd;
    assign rx_push   = s_q.rxp;
    assign cs_n      = s_q.csn;
endmodule

// File: rtl/spi_blk_engine_chk.sv
module spi_blk_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic        reg_sel,
    input logic [31:0] reg_wdata,
    input logic [31:0] cmd_rdata,
    input logic [31:0] sts_rdata,
    input logic        tx_pop,
    input logic        rx_push,
    input logic        sclk,
    input logic        mosi,
    input logic [3:0]  cs_n
);
    // R1: an idle start write makes the block run next cycle
    a_r1_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && !reg_sel && reg_wdata[31] && !cmd_rdata[31] |=> cmd_rdata[31]);

    // R3: end of block raises ready
    a_r3_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rdata[31]) |-> sts_rdata[30]);

    // R4: write-one clears ready when no block can complete
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_sel && reg_wdata[30] && !cmd_rdata[31] |=> !sts_rdata[30]);

    // R5: serial clock idles at the polarity bit
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[31] && $past(!cmd_rdata[31]) && $stable(cmd_rdata[29]) |-> sclk == cmd_rdata[29]);

    // R6: at most one chip select active
    a_r6_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R6: hardware mode releases every line when idle
    a_r6_hw_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[21] && !cmd_rdata[31] |-> &cs_n);

    // R7: software mode drives the selected line from the value bit
    a_r7_sw_level: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[21] |-> cs_n[cmd_rdata[27:26]] == cmd_rdata[20]);

    // R8: transmit disabled keeps data out low during a block
    a_r8_quiet_mosi: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[31] && !cmd_rdata[11] |-> !mosi);

    // R8: a pop only accompanies an idle start with transmit enabled
    a_r8_pop_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> reg_we && !reg_sel && reg_wdata[31] && reg_wdata[11] && !cmd_rdata[31]);

    // R9: a push only follows block end with receive enabled
    a_r9_push_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $fell(cmd_rdata[31]) && cmd_rdata[12]);

    // R11: command writes during a block leave configuration unchanged
    a_r11_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && !reg_sel && cmd_rdata[31] |=> $stable(cmd_rdata[30:0]));
endmodule

bind spi_blk_engine spi_blk_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .cmd_rdata (cmd_rdata),
    .sts_rdata (sts_rdata),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n)
);

// File: tb/spi_blk_engine_bench.sv
`timescale 1ns/1ps
module spi_blk_engine_bench;
    localparam int DIV = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] cmd_rdata, sts_rdata, tx_data, rx_data;
    logic        tx_pop, rx_push, sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_n;

    int total = 0;
    int fails = 0;
    int pops  = 0;

    logic [31:0] exp_q[$];

    // slave model state
    logic        slv_on = 1'b0;
    logic        s_cpol, s_cpha;
    logic [31:0] s_pw;
    logic [31:0] cap;
    int          bitcnt, shcnt, t_cnt;
    logic [3:0]  cs_seen;
    time         t_edge [2];

    always #10 clk = ~clk;

    spi_blk_engine #(.DIV(DIV)) u_spi_blk_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .sts_rdata(sts_rdata),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcmd(input logic [1:0] mode, input logic [1:0] sel,
                                          input logic sw, input logic val, input logic lsb,
                                          input logic rx, input logic tx, input logic [4:0] len);
        return {1'b0, 1'b1, mode, sel, 4'b0, sw, val, 3'b0, lsb, 3'b0, rx, tx, 6'b0, len};
    endfunction

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        #2;
        if (tx_pop) pops++;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!cmd_rdata[31]) break;
        end
    endtask

    // slave: capture on capture edges, present next bit on shift edges
    always @(sclk) begin
        if (slv_on) begin
            if (t_cnt < 2) begin t_edge[t_cnt] = $time; t_cnt++; end
            if (sclk == !(s_cpol ^ s_cpha)) begin
                if (bitcnt == 0) cs_seen = cs_n;
                if (bitcnt < 32) cap[bitcnt] = mosi;
                bitcnt++;
            end else if (s_cpha) begin
                miso = (shcnt < 32) ? s_pw[shcnt] : 1'b0;
                shcnt++;
            end else begin
                shcnt++;
                miso = (shcnt < 32) ? s_pw[shcnt] : 1'b0;
            end
        end
    end

    // scoreboard monitor for pushed words (R9)
    always @(negedge clk) begin
        if (rst_n && rx_push) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected push", rx_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(rx_data == e, "R9/R10 received word", rx_data, e);
            end
        end
    end

    task automatic run_block(input logic [31:0] cfg, input logic [31:0] txw,
                             input logic [31:0] pw, input logic busy_write, input string tag);
        int n, p0;
        logic [31:0] exp_tx, exp_rx, snap;
        logic [3:0]  exp_cs;
        n = int'(cfg[4:0]) + 1;
        exp_tx = '0; exp_rx = '0;
        for (int j = 0; j < n; j++) begin
            if (cfg[16]) begin
                exp_tx[j] = cfg[11] ? txw[j] : 1'b0;
                exp_rx[j] = pw[j];
            end else begin
                exp_tx[j] = cfg[11] ? txw[n-1-j] : 1'b0;
                exp_rx[n-1-j] = pw[j];
            end
        end
        exp_cs = (cfg[21] && cfg[20]) ? 4'hF : ~(4'b0001 << cfg[27:26]);
        wr(1'b0, cfg);
        repeat (4) @(negedge clk);
        check(sclk == cfg[29], {tag, " R5 idle level"}, {31'b0, sclk}, {31'b0, cfg[29]});
        s_cpol = cfg[29]; s_cpha = cfg[28]; s_pw = pw;
        cap = '0; bitcnt = 0; shcnt = 0; t_cnt = 0; cs_seen = 4'h0;
        miso = pw[0];
        tx_data = txw;
        if (cfg[12]) exp_q.push_back(exp_rx);
        p0 = pops;
        slv_on = 1'b1;
        wr(1'b0, cfg | 32'h8000_0000);
        check(cmd_rdata[31] == 1'b1, {tag, " R1 busy"}, cmd_rdata, cfg | 32'h8000_0000);
        if (busy_write) begin
            repeat (6) @(negedge clk);
            snap = cmd_rdata;
            wr(1'b0, mkcmd(2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd3) | 32'h8000_0000);
            check(cmd_rdata == snap, {tag, " R11 busy write ignored"}, cmd_rdata, snap);
        end
        wait_idle();
        @(negedge clk);
        slv_on = 1'b0;
        check(cmd_rdata == cfg, {tag, " R1 idle readback"}, cmd_rdata, cfg);
        check(sts_rdata[30] == 1'b1, {tag, " R3 ready"}, sts_rdata, 32'h4000_0000);
        check(bitcnt == n, {tag, " R2 capture edges"}, bitcnt, n);
        check(cap == exp_tx, {tag, " R8/R10 shifted word"}, cap, exp_tx);
        check(cs_seen == exp_cs, {tag, " R6/R7 chip select in block"}, {28'b0, cs_seen}, {28'b0, exp_cs});
        check((pops - p0) == (cfg[11] ? 1 : 0), {tag, " R8 pop count"}, pops - p0, cfg[11] ? 1 : 0);
        check(t_edge[1] - t_edge[0] == 20 * (DIV + 1), {tag, " R12 half period"},
              32'(t_edge[1] - t_edge[0]), 32'(20 * (DIV + 1)));
        wr(1'b1, 32'h4000_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        tx_data = '0;
        repeat (3) @(negedge clk);
        check(cmd_rdata == 32'h0, "R1 reset command", cmd_rdata, 32'h0);
        check(sts_rdata == 32'h0, "R1 reset status", sts_rdata, 32'h0);
        check(cs_n == 4'hF, "R1 reset chip select", {28'b0, cs_n}, 32'hF);
        check(sclk == 1'b0, "R1 reset clock", {31'b0, sclk}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // mode 0, MSB first, 8 bits, both directions, line 0
        run_block(mkcmd(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd7),
                  32'h0000_00A5, 32'h0000_00C3, 1'b0, "blk8");
        // mode 3, LSB first, 32 bits, line 2
        run_block(mkcmd(2'b11, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd31),
                  32'hDEAD_BEEF, 32'h1234_5679, 1'b0, "blk32");
        // mode 1, 13 bits, transmit only
        run_block(mkcmd(2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd12),
                  32'hFFFF_1ACE, 32'h0000_0FFF, 1'b0, "txonly");
        // mode 2, LSB first, 5 bits, receive only
        run_block(mkcmd(2'b10, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd4),
                  32'hFFFF_FFFF, 32'h0000_0016, 1'b0, "rxonly");
        // mode 0, 16 bits, command write mid-block
        run_block(mkcmd(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd15),
                  32'h0000_9C31, 32'h0000_5AF0, 1'b1, "busywr");

        // R4: ready write-one-to-clear
        run_block(mkcmd(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0),
                  32'h1, 32'h0, 1'b0, "blk1");
        wr(1'b0, mkcmd(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2) | 32'h8000_0000);
        wait_idle();
        @(negedge clk);
        wr(1'b1, 32'hBFFF_FFFF);
        check(sts_rdata[30] == 1'b1, "R4 write zero keeps ready", sts_rdata, 32'h4000_0000);
        wr(1'b1, 32'h4000_0000);
        check(sts_rdata[30] == 1'b0, "R4 write one clears ready", sts_rdata, 32'h0);

        // R7: software chip-select control on line 1
        wr(1'b0, mkcmd(2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));
        @(negedge clk);
        check(cs_n == 4'b1101, "R7 software low while idle", {28'b0, cs_n}, 32'hD);
        run_block(mkcmd(2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd9),
                  32'h0000_02B4, 32'h0000_0133, 1'b0, "swlow");
        check(cs_n == 4'b1101, "R7 software low after block", {28'b0, cs_n}, 32'hD);
        run_block(mkcmd(2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd5),
                  32'h0000_0029, 32'h0, 1'b0, "swhigh");
        check(cs_n == 4'hF, "R7 software high after block", {28'b0, cs_n}, 32'hF);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 all expected words pushed", exp_q.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule